// File: doc/BRIEF.md
# Segmented Two-Level Address Translator

This block maps a 6-bit virtual address to a 5-bit physical address in two table steps. The top two address bits select one of four segment descriptors. Each descriptor holds a present flag and a 2-bit number that names one of four page maps. The next two address bits select an entry in that page map. The entry holds a valid flag and a 3-bit frame number. The physical address is that frame followed by the unchanged 2-bit offset.

The block reports two faults, and they never occur together. A missing segment is a fatal segmentation fault, and in that case no page map is looked up. An invalid page entry is a recoverable page fault. A lookup is accepted with a single valid strobe, and its result appears one clock later. A write port fills the segment descriptors and the page-map entries. After reset, every entry is absent or invalid.

Top module: `seg_xlate`

## Requirements
- R1: After reset, `rsp_valid`, both fault flags and `rsp_paddr` are 0. Every segment descriptor is not present and every page entry is invalid, so any lookup then returns a segmentation fault.
- R2: The segment number is `req_vaddr[5:4]`, the page number is `req_vaddr[3:2]` and the offset is `req_vaddr[1:0]`. On a successful lookup, `rsp_paddr` is {frame[2:0], offset[1:0]}.
- R3: `rsp_valid` is high in the cycle after a clock edge that sees `req_valid` high, and low after an edge that sees `req_valid` low.
- R4: If the selected segment descriptor is not present, the response has `rsp_segfault`=1, `rsp_pagefault`=0 and `rsp_paddr`=0, whatever the page maps hold.
- R5: If the segment is present and the selected page entry is invalid, the response has `rsp_pagefault`=1, `rsp_segfault`=0 and `rsp_paddr`=0.
- R6: The 2-bit table number in a present descriptor picks which of the four page maps is indexed. Segments that name different maps return different frames for the same page number.
- R7: A write with `wr_en`=1 and `wr_sel`=0 stores into descriptor `wr_index`: `wr_data[2]` is the present flag and `wr_data[1:0]` is the table number. A write with `wr_sel`=1 stores into entry `wr_index` of page map `wr_table`: `wr_data[3]` is the valid flag and `wr_data[2:0]` is the frame.
- R8: A lookup in the same cycle as a write translates with the table contents from before the write. The next lookup sees the new contents.
- R9: The two fault flags are never high together. When `rsp_valid` is low, both flags and `rsp_paddr` are 0.
- R10: Load descriptor 2 as present with table 3, and load entry 1 of map 3 as valid with frame 5. Virtual address 6'b100110 then translates to physical 5'b10110 with no fault.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Lookup request strobe |
| req_vaddr | input | 6 | Virtual address to translate |
| rsp_valid | output | 1 | Result valid, one cycle after the request |
| rsp_paddr | output | 5 | Physical address, 0 on a fault |
| rsp_segfault | output | 1 | Fatal fault: segment not present |
| rsp_pagefault | output | 1 | Recoverable fault: page entry invalid |
| wr_en | input | 1 | Table write strobe |
| wr_sel | input | 1 | 0 writes a segment descriptor, 1 writes a page entry |
| wr_table | input | 2 | Page map number for a page-entry write |
| wr_index | input | 2 | Descriptor or page entry index |
| wr_data | input | 4 | Entry contents, layout as in R7 |

## Verification
A table write and a translation can fall in the same cycle. This matters most when the write changes the very descriptor or page entry that the lookup reads. The bench provokes the case by driving both strobes in one cycle. One such write removes the segment behind address 100110, and another invalidates the page entry behind a working address. The response in that cycle must match the table contents from before the write. The lookup right after it must show the new segmentation fault or page fault.

// File: rtl/seg_xlate.sv
module seg_xlate #(
  parameter int SEG_W   = 2,
  parameter int PAGE_W  = 2,
  parameter int OFF_W   = 2,
  parameter int FRAME_W = 3,
  parameter int PTSEL_W = 2,
  localparam int VA_W   = SEG_W + PAGE_W + OFF_W,
  localparam int PA_W   = FRAME_W + OFF_W,
  localparam int IDX_W  = (SEG_W > PAGE_W) ? SEG_W : PAGE_W,
  localparam int SD_W   = PTSEL_W + 1,
  localparam int PD_W   = FRAME_W + 1,
  localparam int WD_W   = (SD_W > PD_W) ? SD_W : PD_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid,
  input  logic [VA_W-1:0]    req_vaddr,
  output logic               rsp_valid,
  output logic [PA_W-1:0]    rsp_paddr,
  output logic               rsp_segfault,
  output logic               rsp_pagefault,
  input  logic               wr_en,
  input  logic               wr_sel,
  input  logic [PTSEL_W-1:0] wr_table,
  input  logic [IDX_W-1:0]   wr_index,
  input  logic [WD_W-1:0]    wr_data
);
  localparam int NSEG  = 1 << SEG_W;
  localparam int NPAGE = 1 << PAGE_W;
  localparam int NPT   = 1 << PTSEL_W;

  logic [NSEG-1:0]    seg_present;
  logic [PTSEL_W-1:0] seg_pt   [NSEG];
  logic [NPAGE-1:0]   pg_valid [NPT];
  logic [FRAME_W-1:0] pg_frame [NPT][NPAGE];

  wire [SEG_W-1:0]   seg_idx  = req_vaddr[VA_W-1 -: SEG_W];
  wire [PAGE_W-1:0]  page_idx = req_vaddr[OFF_W +: PAGE_W];
  wire [OFF_W-1:0]   offset   = req_vaddr[OFF_W-1:0];
  wire               seg_ok   = seg_present[seg_idx];
  wire [PTSEL_W-1:0] pt_sel   = seg_pt[seg_idx];
  wire               pg_ok    = pg_valid[pt_sel][page_idx];
  wire [FRAME_W-1:0] frame    = pg_frame[pt_sel][page_idx];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seg_present <= '0;
      for (int s = 0; s < NSEG; s++) seg_pt[s] <= '0;
      for (int t = 0; t < NPT; t++) begin
        pg_valid[t] <= '0;
        for (int p = 0; p < NPAGE; p++) pg_frame[t][p] <= '0;
      end
    end else if (wr_en) begin
      if (!wr_sel) begin
        seg_present[wr_index[SEG_W-1:0]] <= wr_data[SD_W-1];
        seg_pt[wr_index[SEG_W-1:0]]      <= wr_data[PTSEL_W-1:0];
      end else begin
        pg_valid[wr_table][wr_index[PAGE_W-1:0]] <= wr_data[PD_W-1];
        pg_frame[wr_table][wr_index[PAGE_W-1:0]] <= wr_data[FRAME_W-1:0];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid     <= 1'b0;
      rsp_paddr     <= '0;
      rsp_segfault  <= 1'b0;
      rsp_pagefault <= 1'b0;
    end else begin
      rsp_valid     <= req_valid;
      rsp_segfault  <= req_valid && !seg_ok;
      rsp_pagefault <= req_valid && seg_ok && !pg_ok;
      rsp_paddr     <= (req_valid && seg_ok && pg_ok) ? {frame, offset} : '0;
    end
  end

  // R9
  fault_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(rsp_segfault && rsp_pagefault));

  // R9
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rsp_valid |-> (!rsp_segfault && !rsp_pagefault && rsp_paddr == '0));

  // R3
  rsp_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid);

  // R3
  rsp_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !rsp_valid);

  // R4
  segfault_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_segfault |-> (rsp_paddr == '0 && rsp_valid));

  // R2
  offset_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid ##1 (!rsp_segfault && !rsp_pagefault)) |->
      rsp_paddr[OFF_W-1:0] == $past(req_vaddr[OFF_W-1:0]));
endmodule

// File: tb/sim_seg_xlate.sv
`timescale 1ns/1ps
module sim_seg_xlate;
  logic       clk = 0;
  logic       rst_n = 0;
  logic       req_valid = 0;
  logic [5:0] req_vaddr = '0;
  logic       rsp_valid;
  logic [4:0] rsp_paddr;
  logic       rsp_segfault, rsp_pagefault;
  logic       wr_en = 0, wr_sel = 0;
  logic [1:0] wr_table = '0, wr_index = '0;
  logic [3:0] wr_data = '0;

  int n_cmp = 0, n_bad = 0;
  bit done = 0;

  logic       m_sp [4];
  logic [1:0] m_spt[4];
  logic       m_pv [4][4];
  logic [2:0] m_pf [4][4];

  always #10 clk = ~clk;

  seg_xlate u0 (.clk, .rst_n, .req_valid, .req_vaddr, .rsp_valid, .rsp_paddr,
                .rsp_segfault, .rsp_pagefault, .wr_en, .wr_sel, .wr_table,
                .wr_index, .wr_data);

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic model_clear();
    for (int i = 0; i < 4; i++) begin
      m_sp[i] = 0; m_spt[i] = 0;
      for (int j = 0; j < 4; j++) begin m_pv[i][j] = 0; m_pf[i][j] = 0; end
    end
  endtask

  task automatic wseg(input logic [1:0] idx, input logic pres, input logic [1:0] pt);
    @(negedge clk);
    wr_en = 1; wr_sel = 0; wr_index = idx; wr_data = {1'b0, pres, pt};
    @(negedge clk);
    wr_en = 0;
    m_sp[idx] = pres; m_spt[idx] = pt;
  endtask

  task automatic wpg(input logic [1:0] pt, input logic [1:0] idx, input logic v, input logic [2:0] fr);
    @(negedge clk);
    wr_en = 1; wr_sel = 1; wr_table = pt; wr_index = idx; wr_data = {v, fr};
    @(negedge clk);
    wr_en = 0;
    m_pv[pt][idx] = v; m_pf[pt][idx] = fr;
  endtask

  // expected {segfault, pagefault, paddr}
  function automatic logic [6:0] expect_of(input logic [5:0] va);
    logic [1:0] s, p, t;
    s = va[5:4]; p = va[3:2];
    if (!m_sp[s]) return {2'b10, 5'd0};
    t = m_spt[s];
    if (!m_pv[t][p]) return {2'b01, 5'd0};
    return {2'b00, m_pf[t][p], va[1:0]};
  endfunction

  task automatic lookup(input string tag, input logic [5:0] va);
    logic [6:0] e;
    e = expect_of(va);
    @(negedge clk);
    req_valid = 1; req_vaddr = va;
    @(negedge clk);
    req_valid = 0;
    chk({tag, " R3 valid"}, rsp_valid, 1);
    chk({tag, " segfault"}, rsp_segfault, e[6]);
    chk({tag, " pagefault"}, rsp_pagefault, e[5]);
    chk({tag, " paddr"}, rsp_paddr, e[4:0]);
  endtask

  task automatic t_reset();
    chk("R1 rsp_valid", rsp_valid, 0);
    chk("R1 flags", {rsp_segfault, rsp_pagefault}, 0);
    chk("R1 paddr", rsp_paddr, 0);
    for (int v = 0; v < 64; v += 13) lookup("R1 R4 empty", 6'(v));
  endtask

  task automatic t_example();
    wseg(0, 1, 0); wseg(1, 0, 2); wseg(2, 1, 3); wseg(3, 1, 1);
    wpg(3, 1, 1, 3'd5);
    lookup("R10 example", 6'b100110);
    chk("R10 paddr", rsp_paddr, 5'b10110);
  endtask

  task automatic t_segfault();
    wpg(2, 0, 1, 3'd7); wpg(2, 3, 1, 3'd2);
    lookup("R4 absent", 6'b010001);
    lookup("R4 absent2", 6'b011111);
  endtask

  task automatic t_pagefault();
    lookup("R5 invalid", 6'b001011);
    wpg(0, 2, 1, 3'd6);
    lookup("R7 R5 now valid", 6'b001011);
    chk("R7 paddr", rsp_paddr, {3'd6, 2'b11});
  endtask

  task automatic t_select();
    wpg(1, 2, 1, 3'd1); wpg(3, 2, 1, 3'd4);
    lookup("R6 seg3 pt1", 6'b111001);
    chk("R6 seg3 frame", rsp_paddr, {3'd1, 2'b01});
    lookup("R6 seg2 pt3", 6'b101001);
    chk("R6 seg2 frame", rsp_paddr, {3'd4, 2'b01});
    wseg(3, 1, 3);
    lookup("R6 R7 seg3 repointed", 6'b111010);
    chk("R6 seg3 new frame", rsp_paddr, {3'd4, 2'b10});
    for (int v = 0; v < 64; v += 5) lookup("R2 sweep", 6'(v));
  endtask

  task automatic t_idle();
    @(negedge clk);
    @(negedge clk);
    chk("R3 idle valid", rsp_valid, 0);
    chk("R9 idle flags", {rsp_segfault, rsp_pagefault}, 0);
    chk("R9 idle paddr", rsp_paddr, 0);
  endtask

  task automatic t_collide();
    @(negedge clk);
    req_valid = 1; req_vaddr = 6'b100110;
    wr_en = 1; wr_sel = 0; wr_index = 2; wr_data = 4'b0011;
    @(negedge clk);
    req_valid = 0; wr_en = 0;
    chk("R8 old hit segfault", rsp_segfault, 0);
    chk("R8 old hit paddr", rsp_paddr, 5'b10110);
    m_sp[2] = 0;
    lookup("R8 after seg write", 6'b100110);
    chk("R8 now segfault", rsp_segfault, 1);
    @(negedge clk);
    req_valid = 1; req_vaddr = 6'b001011;
    wr_en = 1; wr_sel = 1; wr_table = 0; wr_index = 2; wr_data = 4'b0000;
    @(negedge clk);
    req_valid = 0; wr_en = 0;
    chk("R8 old page paddr", rsp_paddr, {3'd6, 2'b11});
    chk("R8 old page flag", rsp_pagefault, 0);
    m_pv[0][2] = 0;
    lookup("R8 after page write", 6'b001011);
    chk("R8 now pagefault", rsp_pagefault, 1);
  endtask

  initial begin
    #(20 * 200000);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    model_clear();
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_example();
    t_segfault();
    t_pagefault();
    t_select();
    t_idle();
    t_collide();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule